// File: doc/BRIEF.md
# Microcoded Instruction Control Sequencer

This block sequences a small 16-bit processor through its instructions. In a fetch cycle it puts the program counter on the bus address and captures the returned word in an instruction register. It then steps through a microprogram, one step per cycle. The opcode field of the instruction register, joined with the binary index of the current step, addresses a writable micro-store. The word read there is latched into a microinstruction register, which drives the control outputs to the datapath.

The step position is held in a one-hot ring counter. A dedicated flag bit in each micro-word marks the last step of an instruction. When that flag is set, or when the ring reaches its final position, the program counter advances, the ring returns to its first position and the next fetch follows. The micro-store is a RAM that is loaded through a simple write port. Loading is accepted only while the run input is low, so software or a boot controller can change the microcode between runs. An active-low reset aborts whatever is in progress and restarts at the reset vector.

Top module: `uctl_sequencer`

## Requirements
- R1: While reset is asserted, bus_addr_o equals the reset vector (default 16'h0100), step_o is 8'b0000_0001, ctrl_o is zero and ir_o is zero.
- R2: In a fetch cycle with run_i high, bus_rd_o is 1 and bus_addr_o is the program counter. At the clock edge that ends that cycle, ir_o takes the value of bus_rdata_i.
- R3: Each execute cycle reads the micro-store at address {ir_o[15:12], binary index of the hot bit of step_o}, a 7-bit address. In a stored word, bit 15 is the end-of-instruction flag and bits 14:0 are the control field.
- R4: The control field read in the execute cycle of step k appears on ctrl_o in the following cycle. ctrl_o is zero in the first execute cycle of every instruction.
- R5: step_o always has exactly one bit set. It is bit 0 in the first execute cycle of an instruction and moves up by one bit position in each further execute cycle.
- R6: When the word read in an execute cycle has its end flag set, the next cycle is a fetch at the program counter plus one, and step_o returns to bit 0.
- R7: An execute cycle at step 7 (step_o bit 7) ends the instruction in the same way as R6, even if the end flag is clear.
- R8: While run_i is low, bus_rd_o is 0 and the program counter, step_o, ir_o and ctrl_o hold their values.
- R9: A write (uw_en_i high) of uw_data_i to micro-store address uw_addr_i, in the R3 address layout, takes effect only in a cycle with run_i low. A write attempted while run_i is high leaves the micro-store unchanged.
- R10: Asserting rst_n low at any time, including in the middle of an instruction, aborts the instruction at once and returns the block to the R1 state. After release, the first fetch is from the reset vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously at chip level |
| run_i | input | 1 | High: sequence instructions. Low: hold, and allow micro-store writes |
| bus_rdata_i | input | 16 | Instruction word returned from the data bus |
| bus_addr_o | output | 16 | Fetch address (program counter) |
| bus_rd_o | output | 1 | Fetch read strobe |
| ir_o | output | 16 | Instruction register |
| ctrl_o | output | 15 | Control field of the microinstruction register |
| step_o | output | 8 | One-hot microprogram step |
| uw_en_i | input | 1 | Micro-store write enable |
| uw_addr_i | input | 7 | Micro-store write address {opcode, step index} |
| uw_data_i | input | 16 | Micro-store write data {end flag, control field} |

## Verification
The bench runs opcodes of one, two, four and eight steps. An eight-step opcode with no end flag shows whether the ring stops at its final position: a design that wraps would run forever or repeat steps, and the fetch address would never advance. It checks that ctrl_o shows zero in the first execute cycle and then the step words one cycle late. Off-by-one pipelining would show the wrong step's word, or the previous instruction's last word, in that bubble. A write attempted during execution targets an opcode that runs later, so a store that lets the write through would show the wrong control word and lose the end flag. A reset in the middle of an eight-step instruction, followed by a microcode rewrite while halted, shows whether reset clears the ring and the program counter and whether writes taken while halted are used.

// File: rtl/uctl_pkg.sv
package uctl_pkg;
  typedef enum logic {
    PH_FETCH = 1'b0,
    PH_EXEC  = 1'b1
  } phase_e;
endpackage

// File: rtl/uctl_ring.sv
module uctl_ring #(
  parameter int STEPS = 8,
  localparam int SW = $clog2(STEPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [STEPS-1:0] ring_o,
  output logic [SW-1:0]    idx_o
);
  logic [STEPS-1:0] ring_q, ring_d;

  always_comb begin
    ring_d = ring_q;
    if (clr_i)      ring_d = STEPS'(1);
    else if (adv_i) ring_d = {ring_q[STEPS-2:0], ring_q[STEPS-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ring_q <= STEPS'(1);
    else        ring_q <= ring_d;
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < STEPS; i++) begin
      if (ring_q[i]) idx_o = idx_o | SW'(i);
    end
  end

  assign ring_o = ring_q;

  // R5: exactly one hot bit at every edge out of reset
  p_ring_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ring_q) == 1);
endmodule

// File: rtl/uctl_store.sv
module uctl_store #(
  parameter int AW = 7,
  parameter int WW = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [WW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  input  logic          rd_en_i,
  input  logic          clr_i,
  output logic [WW-1:0] rword_o,
  output logic [WW-1:0] uir_o
);
  logic [WW-1:0] mem_q [DEPTH];
  logic [WW-1:0] uir_q, uir_d;
  logic          wr_ok;

  assign wr_ok = we_i && !busy_i;

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[waddr_i] <= wdata_i;
  end

  assign rword_o = mem_q[raddr_i];

  always_comb begin
    uir_d = uir_q;
    if (clr_i)        uir_d = '0;
    else if (rd_en_i) uir_d = rword_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uir_q <= '0;
    else        uir_q <= uir_d;
  end

  assign uir_o = uir_q;

  // R8: with neither read nor clear the microinstruction register holds
  p_uir_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_i && !clr_i) |=> $stable(uir_q));
endmodule

// File: rtl/uctl_fetch.sv
module uctl_fetch
  import uctl_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [AW-1:0] RST_VEC = 16'h0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          end_i,
  input  logic [DW-1:0] rdata_i,
  output logic          fetch_o,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] ir_o
);
  phase_e        ph_q, ph_d;
  logic [AW-1:0] pc_q, pc_d;
  logic [DW-1:0] ir_q, ir_d;

  always_comb begin
    ph_d = ph_q;
    pc_d = pc_q;
    ir_d = ir_q;
    if (run_i) begin
      if (ph_q == PH_FETCH) begin
        ir_d = rdata_i;
        ph_d = PH_EXEC;
      end else if (end_i) begin
        pc_d = pc_q + AW'(1);
        ph_d = PH_FETCH;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_FETCH;
      pc_q <= RST_VEC;
      ir_q <= '0;
    end else begin
      ph_q <= ph_d;
      pc_q <= pc_d;
      ir_q <= ir_d;
    end
  end

  assign fetch_o = (ph_q == PH_FETCH);
  assign pc_o    = pc_q;
  assign ir_o    = ir_q;

  // R2: a fetch with run high captures the bus word
  p_ir_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && fetch_o) |=> (ir_q == $past(rdata_i)));
endmodule

// File: rtl/uctl_sequencer.sv
module uctl_sequencer
  import uctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int OPC_W  = 4,
  parameter int STEPS  = 8,
  parameter int CTRL_W = 15,
  parameter logic [ADDR_W-1:0] RST_VEC = 16'h0100,
  localparam int SW  = $clog2(STEPS),
  localparam int UAW = OPC_W + SW,
  localparam int UWW = CTRL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_rd_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [STEPS-1:0]  step_o,
  input  logic              uw_en_i,
  input  logic [UAW-1:0]    uw_addr_i,
  input  logic [UWW-1:0]    uw_data_i
);
  logic           fetch, fetch_now, exec_now, done;
  logic [SW-1:0]  step_idx;
  logic [UAW-1:0] raddr;
  logic [UWW-1:0] rword, uir;
  logic [ADDR_W-1:0] pc;

  assign fetch_now = run_i && fetch;
  assign exec_now  = run_i && !fetch;
  assign done      = exec_now && (rword[UWW-1] || step_o[STEPS-1]);
  assign raddr     = {ir_o[DATA_W-1 -: OPC_W], step_idx};

  uctl_fetch #(.AW(ADDR_W), .DW(DATA_W), .RST_VEC(RST_VEC)) u_fetch (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (run_i),
    .end_i   (done),
    .rdata_i (bus_rdata_i),
    .fetch_o (fetch),
    .pc_o    (pc),
    .ir_o    (ir_o)
  );

  uctl_ring #(.STEPS(STEPS)) u_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (fetch_now || done),
    .adv_i  (exec_now && !done),
    .ring_o (step_o),
    .idx_o  (step_idx)
  );

  uctl_store #(.AW(UAW), .WW(UWW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy_i  (run_i),
    .we_i    (uw_en_i),
    .waddr_i (uw_addr_i),
    .wdata_i (uw_data_i),
    .raddr_i (raddr),
    .rd_en_i (exec_now),
    .clr_i   (fetch_now),
    .rword_o (rword),
    .uir_o   (uir)
  );

  assign bus_addr_o = pc;
  assign bus_rd_o   = fetch_now;
  assign ctrl_o     = uir[CTRL_W-1:0];

  // R6: an ending step leads to a fetch at pc+1 with the ring back at bit 0
  p_end_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (fetch && step_o[0] && pc == $past(pc) + ADDR_W'(1)));

  // R7: the final ring position always ends the instruction
  p_last_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_now && step_o[STEPS-1]) |=> fetch);

  // R8: halted means no motion of pc or step
  p_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> ($stable(pc) && $stable(step_o)));

  // R4: first execute cycle of an instruction shows an empty control field
  p_bubble_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_now |=> (ctrl_o == '0));
endmodule

// File: tb/tb_uctl_sequencer.sv
module tb_uctl_sequencer;
  localparam logic [15:0] RV = 16'h0100;
  localparam int NPROG = 6;
  // each entry: {opcode, expected step count}
  localparam logic [7:0] PROG [NPROG] = '{
    {4'h1, 4'd2}, {4'h0, 4'd1}, {4'h7, 4'd8},
    {4'hF, 4'd8}, {4'h0, 4'd1}, {4'h3, 4'd4}
  };

  logic        clk, rst_n, run, bus_rd, uw_en;
  logic [15:0] bus_rdata, bus_addr, ir, uw_data;
  logic [14:0] ctrl;
  logic [7:0]  step;
  logic [6:0]  uw_addr;
  int n_chk, n_fail;
  bit finished;

  uctl_sequencer dut (
    .clk(clk), .rst_n(rst_n), .run_i(run), .bus_rdata_i(bus_rdata),
    .bus_addr_o(bus_addr), .bus_rd_o(bus_rd), .ir_o(ir), .ctrl_o(ctrl),
    .step_o(step), .uw_en_i(uw_en), .uw_addr_i(uw_addr), .uw_data_i(uw_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] instr_at(input int idx);
    if (idx >= 0 && idx < NPROG) return {PROG[idx][7:4], 12'(12'h120 + idx)};
    return 16'h7000;
  endfunction

  // end flag when opcode < 8 and step == opcode; opcodes 8..15 never set it
  function automatic logic [15:0] uword(input int opc, input int stp);
    logic e;
    e = (opc < 8) && (stp == opc);
    return {e, 4'(opc), 3'(stp), 8'h5A};
  endfunction

  always_comb bus_rdata = instr_at(int'(bus_addr) - int'(RV));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; finished = 0;
    rst_n = 1'b0; run = 1'b0; uw_en = 1'b0; uw_addr = '0; uw_data = '0;
    tick(); tick();
    chk("R1 pc", 32'(bus_addr), 32'(RV));
    chk("R1 step", 32'(step), 32'h1);
    chk("R1 ctrl", 32'(ctrl), 32'h0);
    chk("R1 ir", 32'(ir), 32'h0);
    rst_n = 1'b1;

    // load microcode while halted (R9)
    for (int o = 0; o < 16; o++) begin
      for (int s = 0; s < 8; s++) begin
        uw_en = 1'b1; uw_addr = {4'(o), 3'(s)}; uw_data = uword(o, s);
        tick();
      end
    end
    uw_en = 1'b0;
    run = 1'b1;
    #1;

    for (int i = 0; i < NPROG; i++) begin
      int opc, n;
      opc = int'(PROG[i][7:4]);
      n = int'(PROG[i][3:0]);
      chk("R2 rd", 32'(bus_rd), 32'h1);
      chk("R6 fetch addr", 32'(bus_addr), 32'(RV + 16'(i)));
      if (i > 0)
        chk("R4 last word", 32'(ctrl),
            32'(uword(int'(PROG[i-1][7:4]), int'(PROG[i-1][3:0]) - 1) & 16'h7FFF));
      if (i == 2) begin
        // R9: write during execution must be ignored (opcode 0 step 0)
        uw_en = 1'b1; uw_addr = 7'h00; uw_data = 16'h7FFF;
      end
      tick();
      uw_en = 1'b0;
      chk("R2 ir", 32'(ir), 32'(instr_at(i)));
      chk("R5 first step", 32'(step), 32'h1);
      chk("R4 bubble", 32'(ctrl), 32'h0);
      for (int s = 1; s < n; s++) begin
        tick();
        chk("R5 step", 32'(step), 32'(8'(1) << s));
        chk("R3 word", 32'(ctrl), 32'(uword(opc, s - 1) & 16'h7FFF));
      end
      tick();
    end
    // index 3 was opcode 15 (no end flag): R7 forced end reached index 4

    run = 1'b0;
    #1;
    chk("R8 rd low", 32'(bus_rd), 32'h0);
    tick(); tick(); tick();
    chk("R8 pc hold", 32'(bus_addr), 32'(RV + 16'd6));
    chk("R8 step hold", 32'(step), 32'h1);
    run = 1'b1;
    tick(); tick(); tick();
    chk("R5 mid step", 32'(step), 32'h4);

    rst_n = 1'b0;
    #1;
    chk("R10 pc", 32'(bus_addr), 32'(RV));
    chk("R10 step", 32'(step), 32'h1);
    chk("R10 ctrl", 32'(ctrl), 32'h0);
    chk("R10 ir", 32'(ir), 32'h0);
    run = 1'b0;
    tick();
    rst_n = 1'b1;
    uw_en = 1'b1; uw_addr = {4'h1, 3'd0}; uw_data = {1'b1, 15'h1234};
    tick();
    uw_en = 1'b0;
    run = 1'b1;
    #1;
    chk("R10 restart", 32'(bus_addr), 32'(RV));
    tick();
    chk("R9 step", 32'(step), 32'h1);
    tick();
    chk("R9 new end", 32'(bus_addr), 32'(RV + 16'd1));
    chk("R9 new word", 32'(ctrl), 32'h1234);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule